// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block decides each cycle whether a new operation may enter a shared multi-stage pipeline. It prevents two operations from needing the same stage in the same cycle. The forbidden spacings between starts are fixed at elaboration time as a collision vector parameter. The block keeps a state vector of spacings that are still forbidden with respect to every operation already in flight.

On each clock the state moves one position toward the bit for one-cycle latency. When an operation starts, the collision vector is also ORed into the state.

A requester raises `req_i`. The grant is a combinational pulse in the same cycle that the start is allowed. A request that cannot be served at once is remembered until it is served.

Two scheduling modes are available:
- **Greedy mode** starts at the earliest permitted cycle.
- **Paced mode** also waits a caller-chosen minimum number of cycles after the previous start. This lets the caller pick a fixed latency cycle other than the greedy one.

Top module: `cvc_ctrl`

## Requirements
- R1: After reset the state vector is all zeros, no grant is given without a request, and the first request is granted in the same cycle it is raised.
- R2: `grant_o` is 1 only in a cycle where the pending or incoming request exists and bit 0 of `state_o` is 0. Bit k-1 of the state means "a start k cycles after now collides", and bit 0 of `CV` stands for a latency of one cycle.
- R3: In the cycle after a grant, `state_o` equals the previous state shifted one place toward bit 0, with 0 entering bit N-1, ORed with `CV`.
- R4: In the cycle after a cycle without a grant, `state_o` equals the previous state shifted one place toward bit 0, with 0 entering bit N-1.
- R5: A request that is not granted stays pending and is granted on the first later cycle in which all start conditions hold, with no further request needed.
- R6: Further requests raised while one is already pending are merged into it and produce no extra grant.
- R7: With `greedy_i` = 1, `min_lat_i` has no effect and a start happens at the smallest permitted latency.
- R8: With `greedy_i` = 0, a grant also needs the count of cycles since the previous grant to be at least `min_lat_i`. Values 0 and 1 impose no limit, values above N+1 act as N+1, and after reset the count counts as N+1.
- R9: A latency larger than N is always permitted: N cycles after the last grant the state is all zeros.
- R10: With the default vector (C1..C7 = 0,0,1,1,0,1,0, so `CV` = 7'b0101100), greedy mode and a request held high, grants repeat with spacings 1, 1, 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request to start one operation |
| greedy_i | input | 1 | 1: earliest permitted start; 0: paced by `min_lat_i` |
| min_lat_i | input | $clog2(N+2) | Minimum spacing between starts in paced mode |
| grant_o | output | 1 | Start of one operation this cycle |
| state_o | output | N | Current forbidden-latency state, bit 0 = one cycle ahead |

## Verification
The bench keeps an arithmetic model of the state, the pending request and the spacing counter. It compares grant and state every cycle over sweeps of every paced spacing from 0 to 9, both modes and several request patterns.

It targets the following corner cases and the failure each would show:
- **Greedy cycle.** A wrong shift direction or a missing OR breaks the 1, 1, 7 greedy cycle.
- **Dropped pending request.** Losing a blocked request shows up as a missing grant.
- **Unmerged requests.** Failing to merge requests shows up as an extra grant.
- **Spacing limits.** A wrong cap or an off-by-one in the spacing counter moves paced grants by a cycle or stalls them for good at large spacings.
- **Return to idle.** A state that does not clear N cycles after the last start blocks a late request that should be served at once.

// File: rtl/cvc_pkg.sv
package cvc_pkg;

    // next value of the single-entry request holder
    typedef struct packed {
        logic pend;
    } cvc_pend_t;

    function automatic logic [31:0] cvc_lat_width(input int unsigned n);
        return $clog2(n + 2);
    endfunction

endpackage

// File: rtl/cvc_state.sv
module cvc_state #(
    parameter int unsigned    N  = 7,
    parameter logic [N-1:0]   CV = 7'b0101100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic [N-1:0] state_o,
    output logic         free_o
);

    typedef struct packed {
        logic [N-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vec = st_q.vec >> 1;
        if (start_i) begin
            st_d.vec = (st_q.vec >> 1) | CV;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.vec;
    assign free_o  = ~st_q.vec[0];

endmodule

// File: rtl/cvc_pace.sv
module cvc_pace #(
    parameter int unsigned N    = 7,
    parameter int unsigned LATW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            greedy_i,
    input  logic [LATW-1:0] min_lat_i,
    output logic            lat_ok_o
);

    localparam logic [LATW-1:0] SAT = LATW'(N + 1);

    typedef struct packed {
        logic [LATW-1:0] since;
    } pace_t;

    pace_t pc_d, pc_q;
    logic [LATW-1:0] lat_cap;

    always_comb begin
        lat_cap = (min_lat_i > SAT) ? SAT : min_lat_i;
        lat_ok_o = greedy_i | (pc_q.since >= lat_cap);
    end

    always_comb begin
        pc_d = pc_q;
        if (start_i) begin
            pc_d.since = LATW'(1);
        end else if (pc_q.since != SAT) begin
            pc_d.since = pc_q.since + LATW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q.since <= SAT;
        end else begin
            pc_q <= pc_d;
        end
    end

endmodule

// File: rtl/cvc_pend.sv
module cvc_pend
    import cvc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic start_i,
    output logic want_o
);

    cvc_pend_t pd_d, pd_q;

    always_comb begin
        want_o  = req_i | pd_q.pend;
        pd_d    = pd_q;
        pd_d.pend = want_o & ~start_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

endmodule

// File: rtl/cvc_ctrl.sv
module cvc_ctrl
    import cvc_pkg::*;
#(
    parameter int unsigned  N    = 7,
    parameter logic [N-1:0] CV   = 7'b0101100,
    parameter int unsigned  LATW = cvc_lat_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            greedy_i,
    input  logic [LATW-1:0] min_lat_i,
    output logic            grant_o,
    output logic [N-1:0]    state_o
);

    logic want_w;
    logic free_w;
    logic lat_ok_w;
    logic start_w;

    assign start_w = want_w & free_w & lat_ok_w;
    assign grant_o = start_w;

    cvc_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .start_i (start_w),
        .want_o  (want_w)
    );

    cvc_state #(.N(N), .CV(CV)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .state_o (state_o),
        .free_o  (free_w)
    );

    cvc_pace #(.N(N), .LATW(LATW)) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .greedy_i  (greedy_i),
        .min_lat_i (min_lat_i),
        .lat_ok_o  (lat_ok_w)
    );

endmodule

// File: rtl/cvc_ctrl_chk.sv
module cvc_ctrl_chk #(
    parameter int unsigned  N    = 7,
    parameter logic [N-1:0] CV   = 7'b0101100,
    parameter int unsigned  LATW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic            greedy_i,
    input logic [LATW-1:0] min_lat_i,
    input logic            grant_o,
    input logic [N-1:0]    state_o
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (state_o == '0));

    assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !state_o[0]);

    assert_start_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> ((state_o & CV) == CV));

    assert_idle_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_o |=> ($countones(state_o) <= $countones($past(state_o))));

    assert_pending_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !grant_o && !state_o[1]) |=> (!greedy_i || grant_o));

    assert_paced_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> (greedy_i || (min_lat_i <= 1) || !grant_o));

endmodule

bind cvc_ctrl cvc_ctrl_chk #(.N(N), .CV(CV), .LATW(LATW)) u_cvc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .greedy_i  (greedy_i),
    .min_lat_i (min_lat_i),
    .grant_o   (grant_o),
    .state_o   (state_o)
);

// File: tb/test_cvc_ctrl.sv
module test_cvc_ctrl;

    localparam int N    = 7;
    localparam logic [N-1:0] CV = 7'b0101100;
    localparam int LATW = 4;
    localparam int SAT  = N + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic            greedy_i = 1'b1;
    logic [LATW-1:0] min_lat_i = '0;
    logic            grant_o;
    logic [N-1:0]    state_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [N-1:0] m_state;
    int           m_since;
    logic         m_pend;

    always #10 clk = ~clk;

    cvc_ctrl #(.N(N), .CV(CV)) i_cvc_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .greedy_i  (greedy_i),
        .min_lat_i (min_lat_i),
        .grant_o   (grant_o),
        .state_o   (state_o)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_state = '0; m_since = SAT; m_pend = 1'b0;
    endtask

    // one cycle: drive at negedge, compare against the model, advance model
    task automatic step(input logic req, input logic greedy, input int lat,
                        input string tag, output logic got);
        logic want, latok, eg;
        int   cap;
        req_i = req; greedy_i = greedy; min_lat_i = LATW'(lat);
        #1;
        want  = req | m_pend;
        cap   = (lat > SAT) ? SAT : lat;
        latok = greedy || (m_since >= cap);
        eg    = want & ~m_state[0] & latok;
        check_bit(tag, grant_o, eg);
        check_vec(tag, state_o, m_state);
        got = grant_o;
        m_state = eg ? ((m_state >> 1) | CV) : (m_state >> 1);
        m_since = eg ? 1 : ((m_since + 1 > SAT) ? SAT : m_since + 1);
        m_pend  = want & ~eg;
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        logic g;
        int   last, gaps[6], ng;
        do_reset();

        // R1: reset state and immediate first grant
        step(1'b0, 1'b1, 0, "R1 idle after reset", g);
        check_vec("R1 state zero", state_o, '0);
        step(1'b1, 1'b1, 0, "R1 first request", g);
        check_bit("R1 granted at once", g, 1'b1);

        // R3/R2: after one start C3 is forbidden; request at latency 3 waits (R5)
        step(1'b0, 1'b1, 0, "R4 shift", g);
        step(1'b0, 1'b1, 0, "R4 shift", g);
        step(1'b1, 1'b1, 0, "R2 blocked at latency 3", g);
        check_bit("R2 latency 3 refused", g, 1'b0);
        step(1'b1, 1'b1, 0, "R6 merged request", g);
        check_bit("R5 still blocked at latency 4", g, 1'b0);
        step(1'b0, 1'b1, 0, "R5 pending served at latency 5", g);
        check_bit("R5 pending grant", g, 1'b1);
        step(1'b0, 1'b1, 0, "R6 no extra grant", g);
        check_bit("R6 merged gives one grant", g, 1'b0);

        // R9: N idle cycles clear the state
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, 0, "R9 drain", g);
        check_vec("R9 state cleared", state_o, '0);

        // R10 / R7: greedy cycle 1,1,7 with min_lat ignored
        do_reset();
        last = -1; ng = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1, 9, "R7 greedy ignores min_lat", g);
            if (g) begin
                if (last >= 0 && ng < 6) begin gaps[ng] = i - last; ng++; end
                last = i;
            end
        end
        for (int k = 0; k < 6; k++) begin
            checks++;
            if (gaps[k] != ((k % 3 == 2) ? 7 : 1)) begin
                errors++;
                $display("FAIL R10 gap %0d: actual %0d expected %0d", k, gaps[k],
                         (k % 3 == 2) ? 7 : 1);
            end
        end

        // R8: paced sweep over every spacing, continuous and sparse requests
        for (int lat = 0; lat <= 9; lat++) begin
            do_reset();
            for (int i = 0; i < 40; i++)
                step(1'b1, 1'b0, lat, "R8 paced continuous", g);
            for (int i = 0; i < 40; i++)
                step((i % 3) == 0, 1'b0, lat, "R8 paced sparse", g);
            for (int i = 0; i < 30; i++)
                step((i % 5) == 1, (i % 7) < 3, lat, "R5 mixed modes", g);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule